// File: doc/BRIEF.md
# Aliased partial-width register file

This block holds eight 32-bit general registers and lets each one be reached through several overlapping names: the whole register, its lower half-word, its lowest byte, or the byte just above that. One write port and two independent read ports each carry a register index together with a two-bit part selector. A write to a part merges into the stored value, so the bits outside that part keep their contents. A read of a part returns that part shifted down to bit 0, with zeros above it.

Only indices 0 to 3 have the two byte names. A byte selector on indices 4 to 7 is reported as illegal on that port. An illegal write leaves the register file unchanged, and an illegal read returns zero. When a read port addresses the register being written in the same cycle, it returns the merged value that will be stored at the next clock edge. This lets an instruction pipeline issue back-to-back dependent operations without a separate forwarding path.

Top module: `alias_regfile`

## Requirements
- R1: The file holds 8 registers of 32 bits, indexed 0 to 7. Part selector 2'b00 writes and reads all 32 bits.
- R2: An active-low reset clears every register to zero as soon as it is asserted, and the file stays cleared while reset is held.
- R3: Part selector 2'b01 names bits 15:0. A write replaces only those bits from wr_data[15:0] and keeps bits 31:16.
- R4: Part selector 2'b10 names bits 7:0. A write replaces only those bits from wr_data[7:0] and keeps bits 31:8.
- R5: Part selector 2'b11 names bits 15:8. A write stores wr_data[7:0] into bits 15:8 and keeps bits 31:16 and 7:0. A read returns bits 15:8 on read data bits 7:0.
- R6: A byte selector (2'b10 or 2'b11) on index 4 to 7 raises that port's illegal flag. Such a write changes no register, and such a read returns zero.
- R7: A part read returns its value zero-extended to 32 bits: bits 31:16 are zero for 2'b01, and bits 31:8 are zero for 2'b10 and 2'b11.
- R8: A read of the register being written in the same cycle returns the merged value that is stored at the next rising edge.
- R9: A legal write takes effect at the next rising clock edge and changes only the addressed register. With no write enable, no register changes. The two read ports are independent.
- R10: The bits of wr_data above the width of the selected part have no effect on the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register index |
| wr_part | input | 2 | Write part selector |
| wr_data | input | 32 | Write data, right-aligned for part writes |
| wr_illegal | output | 1 | Write selector not allowed for this index |
| ra_idx | input | 3 | Read port A register index |
| ra_part | input | 2 | Read port A part selector |
| ra_data | output | 32 | Read port A data, zero-extended |
| ra_illegal | output | 1 | Read port A selector not allowed |
| rb_idx | input | 3 | Read port B register index |
| rb_part | input | 2 | Read port B part selector |
| rb_data | output | 32 | Read port B data, zero-extended |
| rb_illegal | output | 1 | Read port B selector not allowed |

## Verification
Reads and the illegal flags are combinational, so they are due in the same cycle their inputs are applied. This includes the bypassed merged value during a write. A write reaches the stored state at the first rising edge after it is driven and is visible on a read port from the following falling edge. The bench therefore drives all inputs on a falling edge and samples 5 ns later, before the next rising edge. Each write is checked twice: through the same-cycle bypass, and again one cycle later with a full-width read. Reset is checked the same way, a few nanoseconds after it is asserted in mid-cycle.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 16;

  typedef enum logic [1:0] {
    PART_FULL = 2'b00,
    PART_WORD = 2'b01,
    PART_LO   = 2'b10,
    PART_HI   = 2'b11
  } part_e;

  function automatic logic part_is_byte(input logic [1:0] sel);
    return sel[1];
  endfunction
endpackage

// File: rtl/alias_rf_rstsync.sv
module alias_rf_rstsync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/alias_rf_legal.sv
module alias_rf_legal #(
  parameter int unsigned NREG       = 8,
  parameter int unsigned NBYTE_REGS = 4,
  localparam int unsigned IDXW      = $clog2(NREG)
) (
  input  logic [IDXW-1:0] idx,
  input  logic [1:0]      sel,
  output logic            illegal
);
  import alias_rf_pkg::*;
  always_comb illegal = part_is_byte(sel) && (32'(idx) >= NBYTE_REGS);
endmodule

// File: rtl/alias_rf_merge.sv
module alias_rf_merge #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] new_data,
  input  logic [1:0]      sel,
  output logic [XLEN-1:0] merged
);
  import alias_rf_pkg::*;
  always_comb begin
    merged = old_val;
    case (sel)
      PART_FULL: merged = new_data;
      PART_WORD: merged[HALF_W-1:0] = new_data[HALF_W-1:0];
      PART_LO:   merged[BYTE_W-1:0] = new_data[BYTE_W-1:0];
      PART_HI:   merged[HALF_W-1:BYTE_W] = new_data[BYTE_W-1:0];
      default:   merged = old_val;
    endcase
  end
endmodule

// File: rtl/alias_rf_extract.sv
module alias_rf_extract #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] src,
  input  logic [1:0]      sel,
  input  logic            illegal,
  output logic [XLEN-1:0] rdata
);
  import alias_rf_pkg::*;
  always_comb begin
    rdata = '0;
    if (!illegal) begin
      case (sel)
        PART_FULL: rdata = src;
        PART_WORD: rdata[HALF_W-1:0] = src[HALF_W-1:0];
        PART_LO:   rdata[BYTE_W-1:0] = src[BYTE_W-1:0];
        PART_HI:   rdata[BYTE_W-1:0] = src[HALF_W-1:BYTE_W];
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile #(
  parameter int unsigned NREG       = 8,
  parameter int unsigned XLEN       = 32,
  parameter int unsigned NBYTE_REGS = 4,
  localparam int unsigned IDXW      = $clog2(NREG),
  localparam int unsigned NRD       = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [1:0]      wr_part,
  input  logic [XLEN-1:0] wr_data,
  output logic            wr_illegal,
  input  logic [IDXW-1:0] ra_idx,
  input  logic [1:0]      ra_part,
  output logic [XLEN-1:0] ra_data,
  output logic            ra_illegal,
  input  logic [IDXW-1:0] rb_idx,
  input  logic [1:0]      rb_part,
  output logic [XLEN-1:0] rb_data,
  output logic            rb_illegal
);
  logic                      rst_ni;
  logic [NREG-1:0][XLEN-1:0] regs_q;
  logic [NREG-1:0][XLEN-1:0] regs_d;
  logic [NREG-1:0]           regs_en;
  logic [XLEN-1:0]           wr_merged;
  logic                      wr_commit;

  logic [NRD-1:0][IDXW-1:0]  rd_idx;
  logic [NRD-1:0][1:0]       rd_part;
  logic [NRD-1:0][XLEN-1:0]  rd_src;
  logic [NRD-1:0][XLEN-1:0]  rd_data;
  logic [NRD-1:0]            rd_bad;

  alias_rf_rstsync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_ni)
  );

  alias_rf_legal #(.NREG(NREG), .NBYTE_REGS(NBYTE_REGS)) u_wr_legal (
    .idx     (wr_idx),
    .sel     (wr_part),
    .illegal (wr_illegal)
  );

  alias_rf_merge #(.XLEN(XLEN)) u_merge (
    .old_val  (regs_q[wr_idx]),
    .new_data (wr_data),
    .sel      (wr_part),
    .merged   (wr_merged)
  );

  assign wr_commit = wr_en && !wr_illegal;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_comb begin
      regs_en[g] = wr_commit && (wr_idx == IDXW'(g));
      regs_d[g]  = wr_merged;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)         regs_q[g] <= '0;
      else if (regs_en[g]) regs_q[g] <= regs_d[g];
    end
  end

  assign rd_idx  = {rb_idx, ra_idx};
  assign rd_part = {rb_part, ra_part};

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    alias_rf_legal #(.NREG(NREG), .NBYTE_REGS(NBYTE_REGS)) u_legal (
      .idx     (rd_idx[p]),
      .sel     (rd_part[p]),
      .illegal (rd_bad[p])
    );

    always_comb begin
      if (wr_commit && (wr_idx == rd_idx[p])) rd_src[p] = wr_merged;
      else                                    rd_src[p] = regs_q[rd_idx[p]];
    end

    alias_rf_extract #(.XLEN(XLEN)) u_ext (
      .src     (rd_src[p]),
      .sel     (rd_part[p]),
      .illegal (rd_bad[p]),
      .rdata   (rd_data[p])
    );
  end

  assign ra_data    = rd_data[0];
  assign rb_data    = rd_data[1];
  assign ra_illegal = rd_bad[0];
  assign rb_illegal = rd_bad[1];
endmodule

// File: rtl/alias_rf_chk.sv
module alias_rf_chk #(
  parameter int unsigned NREG       = 8,
  parameter int unsigned XLEN       = 32,
  parameter int unsigned NBYTE_REGS = 4,
  localparam int unsigned IDXW      = $clog2(NREG)
) (
  input logic                      clk,
  input logic                      rst_ni,
  input logic                      wr_en,
  input logic [IDXW-1:0]           wr_idx,
  input logic [1:0]                wr_part,
  input logic                      wr_illegal,
  input logic [IDXW-1:0]           ra_idx,
  input logic [1:0]                ra_part,
  input logic [XLEN-1:0]           ra_data,
  input logic                      ra_illegal,
  input logic [NREG-1:0][XLEN-1:0] regs_q
);
  assert_illegal_keeps_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_illegal) |=> $stable(regs_q));

  assert_idle_keeps_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_en |=> $stable(regs_q));

  assert_word_upper_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !wr_illegal && wr_part == 2'b01) |=>
      regs_q[$past(wr_idx)][31:16] == $past(regs_q[wr_idx][31:16]));

  assert_lo_upper_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !wr_illegal && wr_part == 2'b10) |=>
      regs_q[$past(wr_idx)][31:8] == $past(regs_q[wr_idx][31:8]));

  assert_hi_rest_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !wr_illegal && wr_part == 2'b11) |=>
      (regs_q[$past(wr_idx)][31:16] == $past(regs_q[wr_idx][31:16])) &&
      (regs_q[$past(wr_idx)][7:0] == $past(regs_q[wr_idx][7:0])));

  assert_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (ra_part != 2'b00) |-> (ra_data[31:16] == 16'h0) &&
      (ra_part[1] ? (ra_data[15:8] == 8'h0) : 1'b1));

  assert_illegal_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    ra_illegal |-> (ra_data == '0));

  assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !wr_illegal && ra_idx == wr_idx && ra_part == 2'b00) |=>
      regs_q[$past(wr_idx)] == $past(ra_data));
endmodule

bind alias_regfile alias_rf_chk #(.NREG(NREG), .XLEN(XLEN), .NBYTE_REGS(NBYTE_REGS)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_ni),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_part    (wr_part),
  .wr_illegal (wr_illegal),
  .ra_idx     (ra_idx),
  .ra_part    (ra_part),
  .ra_data    (ra_data),
  .ra_illegal (ra_illegal),
  .regs_q     (regs_q)
);

// File: tb/tb_alias_regfile.sv
`timescale 1ns/1ps
module tb_alias_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_part;
  logic [31:0] wr_data;
  logic        wr_illegal;
  logic [2:0]  ra_idx, rb_idx;
  logic [1:0]  ra_part, rb_part;
  logic [31:0] ra_data, rb_data;
  logic        ra_illegal, rb_illegal;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [8];

  always #10 clk = ~clk;

  alias_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_part(wr_part), .wr_data(wr_data),
    .wr_illegal(wr_illegal),
    .ra_idx(ra_idx), .ra_part(ra_part), .ra_data(ra_data), .ra_illegal(ra_illegal),
    .rb_idx(rb_idx), .rb_part(rb_part), .rb_data(rb_data), .rb_illegal(rb_illegal)
  );

  function automatic logic [31:0] m_merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [1:0] p);
    case (p)
      2'd0:    return d;
      2'd1:    return (old & 32'hFFFF_0000) | (d & 32'h0000_FFFF);
      2'd2:    return (old & 32'hFFFF_FF00) | (d & 32'h0000_00FF);
      default: return (old & 32'hFFFF_00FF) | ((d & 32'h0000_00FF) << 8);
    endcase
  endfunction

  function automatic logic [31:0] m_view(input logic [31:0] v, input logic [1:0] p);
    case (p)
      2'd0:    return v;
      2'd1:    return v & 32'h0000_FFFF;
      2'd2:    return v & 32'h0000_00FF;
      default: return (v >> 8) & 32'h0000_00FF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input int idx, input int part, input logic [31:0] d);
    logic        bad;
    logic [31:0] merged;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_part = 2'(part); wr_data = d;
    ra_idx = 3'(idx); ra_part = 2'(part);
    rb_idx = 3'((idx + 1) % 8); rb_part = 2'd0;
    bad    = (part >= 2) && (idx >= 4);
    merged = bad ? model[idx] : m_merge(model[idx], d, 2'(part));
    #5;
    chk("R6 wr_illegal", {31'd0, wr_illegal}, {31'd0, bad});
    chk("R6 ra_illegal", {31'd0, ra_illegal}, {31'd0, bad});
    // R8 bypass, R7 zero-extension
    chk("R8 bypass read", ra_data, bad ? 32'h0 : m_view(merged, 2'(part)));
    chk("R9 other port", rb_data, model[(idx + 1) % 8]);
    @(posedge clk);
    model[idx] = merged;
    @(negedge clk);
    wr_en = 1'b0; ra_part = 2'd0; rb_idx = 3'(idx); rb_part = 2'(part);
    #5;
    // R3 R4 R5 R10: stored value after merge
    chk("R3/R4/R5/R10 stored", ra_data, model[idx]);
    chk("R7 part read", rb_data, bad ? 32'h0 : m_view(model[idx], 2'(part)));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_part = '0; wr_data = '0;
    ra_idx = '0; ra_part = '0; rb_idx = '0; rb_part = '0;
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    #35 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      ra_idx = 3'(i); rb_idx = 3'(7 - i); ra_part = 2'd0; rb_part = 2'd0;
      #2;
      chk("R2 reset A", ra_data, 32'h0);
      chk("R2 reset B", rb_data, 32'h0);
    end

    // R1 full writes seed every register
    for (int i = 0; i < 8; i++)
      do_write(i, 0, 32'hA5C3_0000 + 32'(i) * 32'h0101_1111);

    for (int k = 0; k < 3; k++)
      for (int i = 0; i < 8; i++)
        for (int p = 1; p < 4; p++)
          do_write(i, p, (32'h9E37_79B9 * 32'(k * 32 + i * 4 + p + 1)) ^ 32'h5A00_F00F);

    for (int i = 0; i < 8; i++) do_write(i, 0, 32'hFFFF_FFFF - 32'(i));
    for (int i = 0; i < 8; i++) do_write(i, 2 + (i % 2), 32'h1234_5600 + 32'(i));

    // R9: idle cycle changes nothing
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ra_idx = 3'(i); ra_part = 2'd0; #1;
      chk("R9 idle unchanged", ra_data, model[i]);
    end

    // R2: reset asserted mid-cycle clears at once
    @(negedge clk);
    ra_idx = 3'd0; rb_idx = 3'd5; ra_part = 2'd0; rb_part = 2'd0;
    #3 rst_n = 1'b0;
    #2;
    chk("R2 async clear A", ra_data, 32'h0);
    chk("R2 async clear B", rb_data, 32'h0);
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_write(2, 3, 32'h0000_00C7);
    do_write(2, 1, 32'hFFFF_1357);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule